// File: doc/BRIEF.md
# Serial Game Pad Responder

This block emulates the device side of a serial game pad. A host raises a latch line, lowers it, then toggles a data clock sixteen times. The block returns the state of twelve buttons on a single serial data line, followed by four padding bits that always read high. A fast system clock oversamples the latch and data clock inputs. Each input passes through a synchronizer and an edge detector, so the host lines need not share a clock with the block.

The controller is a three-state machine: `ST_IDLE`, `ST_LOAD` and `ST_SHIFT`. Transition `T_LATCH` enters `ST_LOAD` from any state while the synchronized latch is high. In that state the button inputs are copied into a frame register on every cycle. Transition `T_RELEASE` (`ST_LOAD` to `ST_SHIFT`) fires when the latch goes low, and it presents bit 1 immediately. Transition `T_STEP` stays in `ST_SHIFT` and advances one bit on each rising data clock edge. Transition `T_END` (`ST_SHIFT` to `ST_IDLE`) fires on the rising edge that follows the sixteenth bit. From then on the line stays low until the next latch.

Top module: `pad_responder`

## Requirements
- R1: While the latch is high the frame register follows `btn_n` every cycle. The bits sent are the button levels present just before the latch falls. Button changes after the fall do not alter the frame.
- R2: Within 4 system cycles of the latch falling, `pad_data` shows bit 1, which is `btn_n[0]`. No data clock edge is needed.
- R3: Bits 2 to 16 each appear after a rising edge of `pad_clk`. Between rising edges the output does not change.
- R4: The bit order is fixed. Bits 1 to 12 are `btn_n[0]` to `btn_n[11]`, meaning B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R. Bits 13 to 16 are always 1.
- R5: A pressed button is a 0 on `btn_n` and is sent as 0. A released button is a 1 and is sent as 1.
- R6: The rising `pad_clk` edge after bit 16 forces `pad_data` to 0. Any further rising edges leave it at 0 until the next latch.
- R7: After reset, and while the latch is high, `pad_data` is 0.
- R8: A latch pulse in the middle of a frame abandons that frame. The register reloads, and the next frame starts again from bit 1.
- R9: Both `pad_latch` and `pad_clk` pass through `SYNC_STAGES` flip-flops and one edge-detect stage. With the default of 2 stages, the output responds to an input edge within 4 system cycles. Each detected rising edge lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_latch | input | 1 | Host latch line, asynchronous |
| pad_clk | input | 1 | Host data clock, idles high, asynchronous |
| btn_n | input | 12 | Button levels, 0 = pressed, bit 0 = B through bit 11 = R |
| pad_data | output | 1 | Serial data line back to the host |

## Verification
The assertions assume that every high and low phase of `pad_latch` and `pad_clk` lasts longer than the synchronizer depth plus one cycle. This guarantees that every edge is seen, and is seen only once. They also assume the data clock is high whenever the latch rises or falls. The stimulus holds each half period of the data clock for 8 system cycles and each latch phase for at least 10 cycles. Latch transitions happen only while the data clock rests high. The button inputs change only at chosen points: inside the latch pulse, or after its fall.

// File: rtl/pad_pkg.sv
package pad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } pad_state_t;
endpackage

// File: rtl/pad_edge_sync.sv
module pad_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9
endmodule

// File: rtl/pad_shifter.sv
module pad_shifter
    import pad_pkg::*;
#(
    parameter int NUM_BUTTONS = 12,
    parameter int FRAME_BITS  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   latch_lvl,
    input  logic                   dclk_rise,
    input  logic [NUM_BUTTONS-1:0] btn_n,
    output logic                   data_out
);
    localparam int CW   = $clog2(FRAME_BITS);
    localparam int PAD  = FRAME_BITS - NUM_BUTTONS;
    localparam int LAST = FRAME_BITS - 1;

    pad_state_t            state, state_nx;
    logic [FRAME_BITS-1:0] sreg;
    logic [CW-1:0]         cnt;
    logic                  last_bit;

    assign last_bit = (cnt == CW'(LAST));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (latch_lvl) state_nx = ST_LOAD;             // T_LATCH
            ST_LOAD:  if (!latch_lvl) state_nx = ST_SHIFT;           // T_RELEASE
            ST_SHIFT: begin
                if (latch_lvl)                  state_nx = ST_LOAD;  // T_LATCH
                else if (dclk_rise && last_bit) state_nx = ST_IDLE;  // T_END
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '1;
            cnt  <= '0;
        end else if (latch_lvl) begin
            sreg <= {{PAD{1'b1}}, btn_n};
            cnt  <= '0;
        end else if (state == ST_SHIFT && dclk_rise && !last_bit) begin
            sreg <= {1'b1, sreg[LAST:1]};                            // T_STEP
            cnt  <= cnt + 1'b1;
        end
    end

    // output
    always_comb begin
        unique case (state)
            ST_SHIFT: data_out = sreg[0];
            default:  data_out = 1'b0;
        endcase
    end

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !latch_lvl) |=> (state == ST_SHIFT && data_out == $past(sreg[0]))); // R2
    AST_STEP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && dclk_rise && !latch_lvl && !last_bit) |=> (data_out == $past(sreg[1]))); // R3
    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !dclk_rise && !latch_lvl) |=> $stable(data_out)); // R3
    AST_PAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        latch_lvl |=> (&sreg[LAST:NUM_BUTTONS])); // R4
    AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && dclk_rise && !latch_lvl && last_bit) |=> !data_out); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !latch_lvl) |=> (state == ST_IDLE && !data_out)); // R6
    AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        latch_lvl |=> !data_out); // R7
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && latch_lvl) |=> (state == ST_LOAD && cnt == '0)); // R8
endmodule

// File: rtl/pad_responder.sv
module pad_responder #(
    parameter int NUM_BUTTONS = 12,
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pad_latch,
    input  logic                   pad_clk,
    input  logic [NUM_BUTTONS-1:0] btn_n,
    output logic                   pad_data
);
    logic latch_lvl, latch_rise_unused;
    logic dclk_lvl_unused, dclk_rise;

    pad_edge_sync #(.STAGES(SYNC_STAGES)) u_latch_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_latch),
        .level (latch_lvl),
        .rise  (latch_rise_unused)
    );

    pad_edge_sync #(.STAGES(SYNC_STAGES)) u_dclk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_clk),
        .level (dclk_lvl_unused),
        .rise  (dclk_rise)
    );

    pad_shifter #(
        .NUM_BUTTONS (NUM_BUTTONS),
        .FRAME_BITS  (FRAME_BITS)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_lvl (latch_lvl),
        .dclk_rise (dclk_rise),
        .btn_n     (btn_n),
        .data_out  (pad_data)
    );
endmodule

// File: tb/test_pad_responder.sv
module test_pad_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pad_latch = 1'b0;
    logic        pad_clk = 1'b1;
    logic [11:0] btn_n = 12'hFFF;
    logic        pad_data;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pad_responder i_pad_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_latch (pad_latch),
        .pad_clk   (pad_clk),
        .btn_n     (btn_n),
        .pad_data  (pad_data)
    );

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: pad_data=%0b expected %0b", tag, act, exp);
        end
    endtask

    // monitor: the host samples on each falling data clock edge
    initial begin
        forever begin
            @(negedge pad_clk);
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pad_data, e, t);
            end
        end
    end

    // driver: one latch (optional) plus nclk data clock cycles
    task automatic run_frame(input bit do_latch, input logic [11:0] early,
                             input logic [11:0] fin, input int nclk, input string tag);
        bit e[$];
        for (int k = 0; k <= nclk; k++) begin
            if (!do_latch || k >= 16) e.push_back(1'b0);
            else if (k < 12)          e.push_back(fin[k]);
            else                      e.push_back(1'b1);
        end
        if (do_latch) begin
            btn_n = early;
            pad_latch = 1'b1;
            ticks(5);
            check(pad_data, 1'b0, {"R7 latch high ", tag});
            btn_n = fin;
            ticks(5);
            pad_latch = 1'b0;
            ticks(6);
            check(pad_data, e[0], {"R2 first bit ", tag});
            btn_n = ~fin;
        end
        for (int k = 0; k < nclk; k++) begin
            exp_q.push_back(e[k]);
            tag_q.push_back($sformatf("%s bit %0d", tag, k + 1));
        end
        for (int k = 0; k < nclk; k++) begin
            pad_clk = 1'b0;
            ticks(8);
            pad_clk = 1'b1;
            ticks(4);
            check(pad_data, e[k+1], $sformatf("R9 R3 after rise %0d %s", k + 1, tag));
            ticks(4);
        end
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(4);
        check(pad_data, 1'b0, "R7 reset");
        run_frame(1'b0, 12'hFFF, 12'hFFF, 3, "R6 clocks before any latch");
        run_frame(1'b1, 12'hFFF, 12'hFFF, 16, "R5 all released");
        run_frame(1'b1, 12'h000, 12'h000, 16, "R5 all pressed");
        run_frame(1'b1, 12'hFFF, 12'hFFA, 16, "R4 B and Select");
        run_frame(1'b1, 12'hFFF, 12'h5A3, 16, "R4 mixed order");
        run_frame(1'b1, 12'h0F0, 12'hE7D, 16, "R1 change inside latch");
        run_frame(1'b1, 12'hFFF, 12'h3C9, 20, "R6 extra clocks");
        run_frame(1'b0, 12'hFFF, 12'hFFF, 2, "R6 idle after frame");
        run_frame(1'b1, 12'hFFF, 12'h000, 5, "R8 aborted frame");
        run_frame(1'b1, 12'hFFF, 12'hA5F, 17, "R8 reloaded frame");
        ticks(10);
        check(pad_data, 1'b0, "R6 final idle");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule